// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned words of a parameterised width `W` (default 8) over several clock cycles, using one adder instead of a full array. A start pulse loads the multiplicand into a holding register and the multiplier into a shift register. It also clears the accumulator. On each following clock, the low bit of the shift register decides whether the multiplicand is added into the accumulator. The adder's carry, the accumulator and the shift register then move one place to the right as a single word. The carry lands in the accumulator's top bit, and the accumulator's low bit lands in the shift register's top bit.

After `W` iterations, the accumulator holds the upper half of the product and the shift register holds the lower half. The block drops its busy flag and raises a one-cycle done pulse. The `2W`-bit result then stays on the output until a new operation is started. A start that arrives while the block is busy is ignored. A start that arrives in the same cycle as the done pulse is accepted, so operations can run back to back with no gap.

Top module: `shift_add_mult`

## Requirements
- R1: A synchronous active-high reset forces `busy` to 0, `done` to 0 and `product` to 0 at the next clock edge, including when it arrives in the middle of an operation.
- R2: When `start` is high while `busy` is low, the operands are captured at that edge and `busy` reads 1 after it.
- R3: `done` goes high exactly `W` clock edges after the edge that accepted `start`, and `busy` is 0 in that same cycle.
- R4: When `done` is high, `product` equals the unsigned product `multiplicand * multiplier`, with the upper `W` bits taken from the accumulator and the lower `W` bits taken from the shift register.
- R5: `done` stays high for a single cycle per operation.
- R6: While idle and with no start, `product` does not change, whatever the operand inputs do.
- R7: A `start` pulse while `busy` is high has no effect on the result or on the completion cycle.
- R8: The carry out of each addition enters the top bit of the accumulator, so all-ones operands yield `(2^W-1)^2`.
- R9: A `start` in the cycle where `done` is high is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| multiplicand | input | W | Unsigned multiplicand |
| multiplier | input | W | Unsigned multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Unsigned product, held until next start |

## Verification
Two functions of the block can fall in the same cycle: the completion pulse of one operation and the acceptance of the next start. The bench raises `start` with fresh operands in exactly the cycle where `done` is observed high. It then checks that `busy` returns at once and that the second product arrives `W` edges later with the correct value. The bench also drives a start with different operands partway through a run, and judges that the completion cycle and the product both match the first operand pair.

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  mq;
  logic [W-1:0]  mcand;
  logic [CW-1:0] cnt;
  logic          busy_q;
  logic          done_q;

  // adder word: top bit is the carry that will shift into acc[W-1]
  logic [W:0] sum;
  assign sum = {1'b0, acc} + {1'b0, (mq[0] ? mcand : {W{1'b0}})};

  wire accept = start && !busy_q;
  wire last   = busy_q && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mq     <= '0;
      mcand  <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        acc    <= '0;
        mq     <= multiplier;
        mcand  <= multiplicand;
        cnt    <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc    <= sum[W:1];
        mq     <= {sum[0], mq[W-1:1]};
        cnt    <= cnt - CW'(1);
        busy_q <= !last;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = {acc, mq};

  // R2: an idle start is taken
  a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R3: completion drops busy
  a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R5: done is a single pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: idle output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));

  // R7: a run is not cut short by a new start
  a_r7_run_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt > CW'(1)) |=> (busy && cnt == $past(cnt) - CW'(1)));

  initial assert (W >= 2);
endmodule

// File: tb/tb_shift_add_mult.sv
module tb_shift_add_mult;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] mc = '0;
  logic [W-1:0] mp = '0;
  logic busy, done;
  logic [2*W-1:0] product;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  shift_add_mult #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(mc), .multiplier(mp),
    .busy(busy), .done(done), .product(product)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch at the current negedge; returns at the negedge after completion.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    mc = a; mp = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    for (int i = 0; i < W - 1; i++) begin
      @(negedge clk);
      if (done !== 1'b0) check("R3 early done", done, 0);
    end
    @(negedge clk);
    check("R3 done at W", done, 1);
    check("R3 busy low", busy, 0);
    check(req, product, 64'(a) * 64'(b));
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 product", product, 0);
  endtask

  task automatic t_basic;
    run(8'd13, 8'd11, "R4 13*11");
    @(negedge clk);
    check("R5 done single", done, 0);
    run(8'd0, 8'd200, "R4 0*200");
    run(8'd200, 8'd0, "R4 200*0");
    run(8'd1, 8'd1, "R4 1*1");
    run(8'd170, 8'd85, "R4 170*85");
    run(8'd128, 8'd2, "R4 128*2");
  endtask

  task automatic t_carry;
    run(8'd255, 8'd255, "R8 255*255");
    run(8'd255, 8'd129, "R8 255*129");
  endtask

  task automatic t_hold;
    logic [2*W-1:0] p;
    run(8'd37, 8'd91, "R4 37*91");
    p = product;
    mc = 8'd5; mp = 8'd6;
    repeat (5) @(negedge clk);
    check("R6 product held", product, p);
    check("R6 no done", done, 0);
  endtask

  task automatic t_ignore;
    mc = 8'd77; mp = 8'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    mc = 8'd250; mp = 8'd250; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mc = 8'd0; mp = 8'd0;
    for (int i = 0; i < W - 4; i++) @(negedge clk);
    check("R7 not done early", done, 0);
    @(negedge clk);
    check("R7 done on time", done, 1);
    check("R7 product of first pair", product, 77 * 3);
  endtask

  task automatic t_backtoback;
    run(8'd9, 8'd9, "R4 9*9");
    run(8'd201, 8'd33, "R9 back-to-back 201*33");
    @(negedge clk);
    check("R5 done cleared", done, 0);
  endtask

  task automatic t_abort;
    mc = 8'd99; mp = 8'd99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 abort busy", busy, 0);
    check("R1 abort product", product, 0);
    repeat (W + 2) @(negedge clk);
    check("R1 no late done", done, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_carry();
    t_hold();
    t_ignore();
    t_backtoback();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule